// File: doc/BRIEF.md
# Shared-Bus Processing Cell Controller

This block is a binary model of one pixel processing cell whose functional units all meet on a single internal bus node. The units are a bank of local one-bit memories, a two-operand logic unit, an optical input register and the sign output of a comparator. Each cycle an instruction, presented as separate enable fields, names the units that drive the node and the units that sample it. One driver may feed any number of samplers in the same cycle.

The controller counts the drivers named by the instruction. With exactly one driver, the node carries that unit's value and every named sampler captures it at the next clock edge. With no driver, nothing is captured. With two or more drivers, the instruction is flagged as a switch conflict and every bus capture in that cycle is blocked. The logic unit holds two operand registers that are loaded from the node and drives its result back onto the node. The optical register is loaded from the sensor pixel input, and the comparator contributes one bit that says whether a signed convolution result is above zero.

Top module: `pcell_bus_ctrl`

## Requirements
- R1: When exactly one source enable is set (rd_mem bit i, rd_lu, rd_opt or rd_cmp), bus_live is 1, conflict is 0 and bus_val equals that source's value in the same cycle.
- R2: When two or more source enables are set, conflict is 1, bus_live is 0, bus_val is 0, and no memory or operand register changes at the next edge.
- R3: When no source enable is set, conflict and bus_live are 0, bus_val is 0, and no memory or operand register changes at the next edge.
- R4: During a live transfer, every memory i with wr_mem bit i set holds the bus value after the next edge; memories whose write bit is clear keep their value, and mem_q bit i shows memory i.
- R5: During a live transfer, wr_op0 loads operand 0 and wr_op1 loads operand 1 from the bus at the next edge; each is loaded only by its own bit.
- R6: The logic unit result, driven onto the bus when rd_lu is the only source, is selected by lu_op: 0 gives op0 AND op1, 1 gives OR, 2 gives XOR, 3 gives NOT op0.
- R7: opt_load captures opt_pix into the optical register at the next edge, independent of the bus and of conflicts; rd_opt is the only path from that register onto the bus.
- R8: The comparator source value is 1 when the signed input cmp_val is greater than zero and 0 when it is zero or negative.
- R9: After reset all memories, both operands and the optical register are 0, and with no enables the outputs are bus_val 0, bus_live 0, conflict 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_mem | input | NMEM | Memory i drives the bus |
| rd_lu | input | 1 | Logic unit result drives the bus |
| rd_opt | input | 1 | Optical register drives the bus |
| rd_cmp | input | 1 | Comparator sign drives the bus |
| wr_mem | input | NMEM | Memory i samples the bus |
| wr_op0 | input | 1 | Operand 0 samples the bus |
| wr_op1 | input | 1 | Operand 1 samples the bus |
| lu_op | input | 2 | Logic unit function select |
| opt_load | input | 1 | Capture sensor pixel into optical register |
| opt_pix | input | 1 | Binary sensor pixel |
| cmp_val | input | CMPW | Signed convolution result for the comparator |
| bus_val | output | 1 | Value on the shared node (0 unless live) |
| bus_live | output | 1 | Exactly one source drives the node |
| conflict | output | 1 | Two or more sources were named |
| mem_q | output | NMEM | Contents of the local memories |

## Verification
The assertions assume that every enable and data input is a known 0 or 1 at each clock edge and that reset is applied before the first instruction; the bench drives all inputs from tasks half a period away from the capturing edge so that no input changes near it. Beyond that, the assertions place no restriction on instructions: conflicting and empty instructions are legal inputs whose effect is checked. The stimulus walks through every combination of source enables, pairing each with pseudo-random sampler sets, functions and sensor values, then adds directed sequences for the four logic functions and for comparator values around zero.

// File: rtl/pcell_pkg.sv
package pcell_pkg;

  typedef enum logic [1:0] {
    LU_AND = 2'd0,
    LU_OR  = 2'd1,
    LU_XOR = 2'd2,
    LU_NOT = 2'd3
  } lu_fn_e;

  // Number of set bits in a source vector of up to 32 entries.
  function automatic int unsigned src_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // Logic unit transfer function.
  function automatic logic lu_eval(input lu_fn_e fn, input logic a, input logic b);
    logic r;
    case (fn)
      LU_AND:  r = a & b;
      LU_OR:   r = a | b;
      LU_XOR:  r = a ^ b;
      default: r = ~a;
    endcase
    return r;
  endfunction

  // Comparator sign: strictly positive gives 1.
  function automatic logic cmp_sign(input logic signed [31:0] v);
    return (v > 0);
  endfunction

endpackage

// File: rtl/pcell_src_sel.sv
module pcell_src_sel #(
  parameter int NSRC = 11
) (
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_dat,
  output logic            one_src,
  output logic            many_src,
  output logic            node_val
);
  import pcell_pkg::*;

  logic [31:0]   en_w;
  int unsigned   cnt;
  logic          picked;

  always_comb begin
    en_w = '0;
    en_w[NSRC-1:0] = src_en;
    cnt  = src_count(en_w);
  end

  assign one_src  = (cnt == 1);
  assign many_src = (cnt > 1);

  // AND-OR mux: only meaningful when exactly one enable is set.
  assign picked   = |(src_en & src_dat);
  assign node_val = one_src & picked;

endmodule

// File: rtl/pcell_logic_unit.sv
module pcell_logic_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld0,
  input  logic       ld1,
  input  logic       bus_in,
  input  logic [1:0] fn_sel,
  output logic       result
);
  import pcell_pkg::*;

  logic opa, opb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa <= 1'b0;
      opb <= 1'b0;
    end else begin
      if (ld0) opa <= bus_in;
      if (ld1) opb <= bus_in;
    end
  end

  assign result = lu_eval(lu_fn_e'(fn_sel), opa, opb);

  // R5
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld0 && !ld1) |=> ($stable(opa) && $stable(opb)));

endmodule

// File: rtl/pcell_lmem_bank.sv
module pcell_lmem_bank #(
  parameter int NMEM = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NMEM-1:0] wr_en,
  input  logic            wr_dat,
  output logic [NMEM-1:0] q
);

  for (genvar i = 0; i < NMEM; i++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bit_q <= 1'b0;
      else if (wr_en[i]) bit_q <= wr_dat;
    end
    assign q[i] = bit_q;
  end

  // R4
  mem_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> (q[0] == $past(wr_dat)));

endmodule

// File: rtl/pcell_bus_ctrl.sv
module pcell_bus_ctrl #(
  parameter int NMEM = 8,
  parameter int CMPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NMEM-1:0] rd_mem,
  input  logic            rd_lu,
  input  logic            rd_opt,
  input  logic            rd_cmp,
  input  logic [NMEM-1:0] wr_mem,
  input  logic            wr_op0,
  input  logic            wr_op1,
  input  logic [1:0]      lu_op,
  input  logic            opt_load,
  input  logic            opt_pix,
  input  logic [CMPW-1:0] cmp_val,
  output logic            bus_val,
  output logic            bus_live,
  output logic            conflict,
  output logic [NMEM-1:0] mem_q
);
  import pcell_pkg::*;

  localparam int NSRC    = NMEM + 3;
  localparam int IDX_LU  = NMEM;
  localparam int IDX_OPT = NMEM + 1;
  localparam int IDX_CMP = NMEM + 2;

  logic [NSRC-1:0] src_en, src_dat;
  logic            lu_res, opt_q, cmp_bit, node;
  logic            one_src, many_src, wr_ok;
  logic signed [31:0] cmp_ext;

  // Optical input register, loaded straight from the sensor pixel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        opt_q <= 1'b0;
    else if (opt_load) opt_q <= opt_pix;
  end

  assign cmp_ext = 32'(signed'(cmp_val));
  assign cmp_bit = cmp_sign(cmp_ext);

  always_comb begin
    src_en            = '0;
    src_dat           = '0;
    src_en[NMEM-1:0]  = rd_mem;
    src_dat[NMEM-1:0] = mem_q;
    src_en[IDX_LU]    = rd_lu;
    src_dat[IDX_LU]   = lu_res;
    src_en[IDX_OPT]   = rd_opt;
    src_dat[IDX_OPT]  = opt_q;
    src_en[IDX_CMP]   = rd_cmp;
    src_dat[IDX_CMP]  = cmp_bit;
  end

  pcell_src_sel #(.NSRC(NSRC)) u_sel (
    .src_en   (src_en),
    .src_dat  (src_dat),
    .one_src  (one_src),
    .many_src (many_src),
    .node_val (node)
  );

  assign wr_ok = one_src;

  pcell_lmem_bank #(.NMEM(NMEM)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_mem & {NMEM{wr_ok}}),
    .wr_dat (node),
    .q      (mem_q)
  );

  pcell_logic_unit u_lu (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld0    (wr_op0 & wr_ok),
    .ld1    (wr_op1 & wr_ok),
    .bus_in (node),
    .fn_sel (lu_op),
    .result (lu_res)
  );

  assign bus_val  = node;
  assign bus_live = one_src;
  assign conflict = many_src;

  // R1
  live_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_live |-> !conflict);

  // R2
  conflict_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> $stable(mem_q));

  // R3
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_live && !conflict) |=> $stable(mem_q));

  // R2
  conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (bus_val == 1'b0));

  // R7
  opt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opt_load |=> (opt_q == $past(opt_pix)));

endmodule

// File: tb/pcell_bus_ctrl_bench.sv
`timescale 1ns/1ps
module pcell_bus_ctrl_bench;
  localparam int NMEM = 8;
  localparam int CMPW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NMEM-1:0] rd_mem = '0, wr_mem = '0, mem_q;
  logic rd_lu = 0, rd_opt = 0, rd_cmp = 0, wr_op0 = 0, wr_op1 = 0;
  logic [1:0] lu_op = '0;
  logic opt_load = 0, opt_pix = 0;
  logic [CMPW-1:0] cmp_val = '0;
  logic bus_val, bus_live, conflict;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [NMEM-1:0] m_mem = '0;
  logic m_op0 = 0, m_op1 = 0, m_opt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  pcell_bus_ctrl #(.NMEM(NMEM), .CMPW(CMPW)) u_pcell_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_mem(rd_mem), .rd_lu(rd_lu), .rd_opt(rd_opt),
    .rd_cmp(rd_cmp), .wr_mem(wr_mem), .wr_op0(wr_op0), .wr_op1(wr_op1),
    .lu_op(lu_op), .opt_load(opt_load), .opt_pix(opt_pix), .cmp_val(cmp_val),
    .bus_val(bus_val), .bus_live(bus_live), .conflict(conflict), .mem_q(mem_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic f_lu(input logic [1:0] op, input logic a, input logic b);
    if (op == 2'd0) return a && b;
    if (op == 2'd1) return a || b;
    if (op == 2'd2) return a != b;
    return !a;
  endfunction

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Apply the currently driven instruction for one cycle and check it.
  task automatic run_cycle();
    int n;
    logic v, live;
    string tg;
    #1;
    n = $countones({rd_mem, rd_lu, rd_opt, rd_cmp});
    v = 1'b0;
    if (n == 1) begin
      for (int i = 0; i < NMEM; i++) if (rd_mem[i]) v = m_mem[i];
      if (rd_lu)  v = f_lu(lu_op, m_op0, m_op1);
      if (rd_opt) v = m_opt;
      if (rd_cmp) v = ($signed(cmp_val) > 0);
    end
    live = (n == 1);
    tg = (n == 1) ? "R1" : ((n > 1) ? "R2" : "R3");
    if (rd_cmp && n == 1) chk("R8 cmp bus", int'(bus_val), int'(v));
    else if (rd_lu && n == 1) chk("R6 lu bus", int'(bus_val), int'(v));
    else chk({tg, " bus_val"}, int'(bus_val), int'(v));
    chk({tg, " bus_live"}, int'(bus_live), int'(live));
    chk({tg, " conflict"}, int'(conflict), int'(n > 1));
    if (live) begin
      for (int i = 0; i < NMEM; i++) if (wr_mem[i]) m_mem[i] = v;
      if (wr_op0) m_op0 = v;
      if (wr_op1) m_op1 = v;
    end
    if (opt_load) m_opt = opt_pix;
    @(posedge clk);
    #1;
    chk(live ? "R4 mem_q" : {tg, " mem hold"}, int'(mem_q), int'(m_mem));
    @(negedge clk);
  endtask

  task automatic idle();
    rd_mem = '0; wr_mem = '0; rd_lu = 0; rd_opt = 0; rd_cmp = 0;
    wr_op0 = 0; wr_op1 = 0; opt_load = 0;
  endtask

  // Load a pixel through the optical register and move it to a destination.
  task automatic put_opt(input logic px, input logic [NMEM-1:0] wm, input logic w0, input logic w1);
    idle(); opt_load = 1; opt_pix = px; run_cycle();
    idle(); rd_opt = 1; wr_mem = wm; wr_op0 = w0; wr_op1 = w1; run_cycle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9 reset state
    #1;
    chk("R9 mem_q", int'(mem_q), 0);
    chk("R9 bus_val", int'(bus_val), 0);
    chk("R9 bus_live", int'(bus_live), 0);
    chk("R9 conflict", int'(conflict), 0);
    rst_n = 1;
    @(negedge clk);
    // R9: optical register and operands read back as zero
    idle(); rd_opt = 1; run_cycle();
    chk("R9 opt zero", int'(bus_val), 0);
    idle(); rd_lu = 1; lu_op = 2'd1; run_cycle();
    chk("R9 operands zero", int'(bus_val), 0);

    // R5/R6: every function with every operand pair
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        put_opt(logic'(a), '0, 1, 0);
        put_opt(logic'(b), '0, 0, 1);
        for (int op = 0; op < 4; op++) begin
          idle(); rd_lu = 1; lu_op = 2'(op); run_cycle();
        end
      end
    end
    // R5: a write to operand 1 alone leaves operand 0 (NOT reads op0)
    put_opt(1, '0, 1, 1);
    put_opt(0, '0, 0, 1);
    idle(); rd_lu = 1; lu_op = 2'd3; wr_mem = 8'h01; run_cycle();
    chk("R5 op0 kept", int'(mem_q[0]), 0);

    // R8: comparator around zero
    foreach (cmp_val[k]) begin end
    for (int c = -3; c <= 3; c++) begin
      idle(); rd_cmp = 1; cmp_val = CMPW'(c); wr_mem = 8'h80; run_cycle();
    end
    idle(); rd_cmp = 1; cmp_val = 8'h80; run_cycle();
    idle(); rd_cmp = 1; cmp_val = 8'h7F; run_cycle();

    // R7: optical load during a conflict still captures
    idle(); rd_mem = 8'h03; opt_load = 1; opt_pix = 1; wr_mem = 8'hFF; run_cycle();
    idle(); rd_opt = 1; wr_mem = 8'h10; run_cycle();
    chk("R7 opt captured in conflict", int'(mem_q[4]), 1);

    // R1..R4: sweep all source combinations
    for (int s = 0; s < (1 << (NMEM + 3)); s++) begin
      next_rand();
      idle();
      {rd_cmp, rd_opt, rd_lu, rd_mem} = (NMEM + 3)'(s);
      wr_mem   = lfsr[7:0];
      wr_op0   = lfsr[8];
      wr_op1   = lfsr[9];
      lu_op    = lfsr[11:10];
      opt_load = lfsr[12];
      opt_pix  = lfsr[13];
      cmp_val  = {lfsr[15:14], lfsr[5:0]};
      run_cycle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule